// File: doc/BRIEF.md
# Crystal Oscillator Control and Stabilization Monitor

This block sits between a register port and the analog driver of an external crystal oscillator. A single control word turns the oscillator on or off, selects whether the root clock comes from the oscillator or straight from an external bypass pin, and sets a 5-bit division factor for the output clock. It also arms a clock-ready interrupt and sets the end-of-count value that decides how long the oscillator must run before its clock counts as stable.

A counter clocked by the oscillator starts at zero whenever the oscillator is on and not bypassed. The oscillator is on after reset. When the counter reaches the end-of-count value times 512, the stable event crosses back into the register clock domain. There it drives a status bit and sets a sticky ready flag, which software clears by writing 1. The interrupt line is the flag gated by a mask bit. Switching the oscillator off, or selecting bypass, returns the counter to zero and drops the status.

Control word layout: bit 0 = oscillator on (1 = on); bit 1 = bypass (1 = external pin is root clock); bit 2 = interrupt enable (1 = enabled); bit 3 = ready flag (read, write 1 to clear); bit 4 = stable status (read only); bits 12:8 = division field; bits 23:16 = end-of-count value. All other bits read as 0.

Top module: `xosc_ctrl`

## Requirements
- R1: After reset the control word reads 0x0001_0001: oscillator on, end-of-count 1, bypass off, interrupt disabled, flag clear, status clear, division field 0. `irq` is 0 and `osc_pwr_en` is 1.
- R2: Once the oscillator runs unbypassed, the ready flag (bit 3) stays 0 until the counter has counted end-of-count × 512 oscillator cycles. It is 1 no more than about 6 further oscillator cycles and 3 register cycles after that.
- R3: Writing 1 to bit 3 clears the flag. Writing 0 to bit 3 leaves the flag unchanged. A set event in the same cycle as a clear wins.
- R4: `irq` is 1 exactly when the flag and the interrupt-enable bit (bit 2) are both 1. It changes in the cycle after the write that alters either one.
- R5: The flag is set at most once per stabilization period. After it is cleared, it stays 0 while the oscillator remains on and unbypassed.
- R6: Clearing bit 0 drops `osc_pwr_en`, resets the counter and drops the status bit and `osc_ready`. Setting bit 0 again starts a full new count.
- R7: With bit 1 set, the root clock is `byp_clk`, the counter is held at zero, and neither status nor flag is raised however long bypass lasts.
- R8: A division field value d divides the root clock by d+1. d=0 passes the root clock through. For d≥1 the output is registered and high for floor((d+1)/2) root cycles of each period.
- R9: The status bit (bit 4) and `osc_ready` are 1 while the count is complete and the oscillator stays on and unbypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control/status word |
| osc_clk | input | 1 | Clock from the crystal oscillator |
| byp_clk | input | 1 | External clock used in bypass |
| osc_pwr_en | output | 1 | Power enable to the oscillator driver |
| osc_ready | output | 1 | Oscillator stable, register clock domain |
| clk_out | output | 1 | Divided root clock |
| irq | output | 1 | Clock-ready interrupt request |

## Verification
Register writes take effect at the first rising edge of `clk`, so `rd_data` and `irq` are sampled at the falling edge that follows. The ready flag is due end-of-count × 512 oscillator periods after power-on, plus the crossing latency. The flag is therefore checked twice: still 0 a margin before that time, and 1 within a bounded poll after it. The status drop after power-off or bypass takes a few cycles in each domain, so it is sampled 20 register cycles later. Divider results are measured as edge-to-edge times on `clk_out`, and only after three output periods have passed since a change.

// File: rtl/xosc_pkg.sv
`timescale 1ns/1ps
package xosc_pkg;
    localparam int WORD_W  = 32;
    localparam int DIV_W   = 5;
    localparam int B_EN    = 0;
    localparam int B_BYP   = 1;
    localparam int B_MASK  = 2;
    localparam int B_FLAG  = 3;
    localparam int B_STAT  = 4;
    localparam int DIV_LSB = 8;
    localparam int EOC_LSB = 16;
endpackage

// File: rtl/xosc_sync.sv
`timescale 1ns/1ps
module xosc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/xosc_stab.sv
`timescale 1ns/1ps
module xosc_stab #(
    parameter int EOC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EOC_W-1:0] eoc,
    output logic             done
);
    localparam int CNT_W = EOC_W + 10;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } st_t;

    st_t st_d, st_q;
    logic run_s;
    logic [CNT_W-1:0] thr;
    logic reached;

    xosc_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
        .clk(osc_clk), .rst_n(rst_n), .d(run), .q(run_s)
    );

    assign thr     = {1'b0, eoc, 9'b0};
    assign reached = (st_q.cnt >= thr);

    always_comb begin
        st_d = st_q;
        if (!run_s) begin
            st_d = '0;
        end else begin
            st_d.done = reached;
            st_d.cnt  = reached ? st_q.cnt : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;

    // R2
    done_thresh_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(st_q.done) |-> ($past(st_q.cnt) >= $past(thr)));

    // R6
    cnt_off_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !run_s |=> (!done && st_q.cnt == '0));
endmodule

// File: rtl/xosc_regs.sv
`timescale 1ns/1ps
module xosc_regs
    import xosc_pkg::*;
#(
    parameter int EOC_W       = 8,
    parameter int EOC_RST     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              done_async,
    output logic [WORD_W-1:0] rd_data,
    output logic              en,
    output logic              byp,
    output logic [DIV_W-1:0]  div,
    output logic [EOC_W-1:0]  eoc,
    output logic              ready,
    output logic              irq
);
    typedef struct packed {
        logic             en;
        logic             byp;
        logic             mask;
        logic             flag;
        logic             done_prev;
        logic [DIV_W-1:0] div;
        logic [EOC_W-1:0] eoc;
    } rs_t;

    rs_t rs_d, rs_q;
    logic done_s, set_evt, clr_req;
    logic unused_wr;

    xosc_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk(clk), .rst_n(rst_n), .d(done_async), .q(done_s)
    );

    assign set_evt   = done_s & ~rs_q.done_prev;
    assign clr_req   = wr_en & wr_data[B_FLAG];
    assign unused_wr = ^wr_data;

    always_comb begin
        rs_d           = rs_q;
        rs_d.done_prev = done_s;
        if (wr_en) begin
            rs_d.en   = wr_data[B_EN];
            rs_d.byp  = wr_data[B_BYP];
            rs_d.mask = wr_data[B_MASK];
            rs_d.div  = wr_data[DIV_LSB +: DIV_W];
            rs_d.eoc  = wr_data[EOC_LSB +: EOC_W];
        end
        rs_d.flag = (rs_q.flag & ~clr_req) | set_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q           <= '0;
            rs_q.en        <= 1'b1;
            rs_q.eoc       <= EOC_W'(EOC_RST);
        end else begin
            rs_q <= rs_d;
        end
    end

    always_comb begin
        rd_data                     = '0;
        rd_data[B_EN]               = rs_q.en;
        rd_data[B_BYP]              = rs_q.byp;
        rd_data[B_MASK]             = rs_q.mask;
        rd_data[B_FLAG]             = rs_q.flag;
        rd_data[B_STAT]             = done_s;
        rd_data[DIV_LSB +: DIV_W]   = rs_q.div;
        rd_data[EOC_LSB +: EOC_W]   = rs_q.eoc;
    end

    assign en    = rs_q.en;
    assign byp   = rs_q.byp;
    assign div   = rs_q.div;
    assign eoc   = rs_q.eoc;
    assign ready = done_s;
    assign irq   = rs_q.flag & rs_q.mask;

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_q.flag && !clr_req) |=> rs_q.flag);

    // R3
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !rs_q.flag);

    // R5
    set_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> !set_evt);
endmodule

// File: rtl/xosc_div.sv
`timescale 1ns/1ps
module xosc_div
    import xosc_pkg::*;
(
    input  logic             osc_clk,
    input  logic             byp_clk,
    input  logic             byp_sel,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             clk_out
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             out;
    } ds_t;

    ds_t ds_d, ds_q;
    logic root_clk;
    logic [DIV_W:0] half;

    assign root_clk = byp_sel ? byp_clk : osc_clk;
    assign half     = ({1'b0, div} + 1'b1) >> 1;

    always_comb begin
        ds_d     = ds_q;
        ds_d.cnt = (ds_q.cnt >= div) ? '0 : ds_q.cnt + 1'b1;
        ds_d.out = ({1'b0, ds_d.cnt} < half);
    end

    always_ff @(posedge root_clk or negedge rst_n) begin
        if (!rst_n) ds_q <= '0;
        else        ds_q <= ds_d;
    end

    assign clk_out = (div == '0) ? root_clk : ds_q.out;

    // R8
    div_wrap_chk: assert property (@(posedge root_clk) disable iff (!rst_n)
        (div != '0 && ds_q.cnt >= div) |=> (ds_q.cnt == '0));
endmodule

// File: rtl/xosc_ctrl.sv
`timescale 1ns/1ps
module xosc_ctrl
    import xosc_pkg::*;
#(
    parameter int EOC_W       = 8,
    parameter int EOC_RST     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              osc_clk,
    input  logic              byp_clk,
    output logic              osc_pwr_en,
    output logic              osc_ready,
    output logic              clk_out,
    output logic              irq
);
    logic             en, byp, done;
    logic [DIV_W-1:0] div;
    logic [EOC_W-1:0] eoc;

    xosc_regs #(.EOC_W(EOC_W), .EOC_RST(EOC_RST), .SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .done_async(done), .rd_data(rd_data), .en(en), .byp(byp),
        .div(div), .eoc(eoc), .ready(osc_ready), .irq(irq)
    );

    xosc_stab #(.EOC_W(EOC_W), .SYNC_STAGES(SYNC_STAGES)) u_stab (
        .osc_clk(osc_clk), .rst_n(rst_n), .run(en & ~byp), .eoc(eoc), .done(done)
    );

    xosc_div u_div (
        .osc_clk(osc_clk), .byp_clk(byp_clk), .byp_sel(byp), .rst_n(rst_n),
        .div(div), .clk_out(clk_out)
    );

    assign osc_pwr_en = en;

    // R6
    pwr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en) && !$past(en, 2) && !$past(en, 3) && !$past(en, 4) && !$past(en, 5)) |-> !osc_ready);
endmodule

// File: tb/xosc_ctrl_test.sv
`timescale 1ns/1ps
module xosc_ctrl_test;
    logic        clk = 0, osc_clk = 0, byp_clk = 0, rst_n = 0;
    logic        wr_en = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        osc_pwr_en, osc_ready, clk_out, irq;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;
    always #15 osc_clk = ~osc_clk;
    always #7  byp_clk = ~byp_clk;

    xosc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .osc_clk(osc_clk), .byp_clk(byp_clk), .osc_pwr_en(osc_pwr_en),
        .osc_ready(osc_ready), .clk_out(clk_out), .irq(irq)
    );

    function automatic logic [31:0] mk(bit en, bit byp, bit msk, bit clr, int dv, int eo);
        logic [31:0] w = '0;
        w[0] = en; w[1] = byp; w[2] = msk; w[3] = clr;
        w[12:8] = 5'(dv); w[23:16] = 8'(eo);
        return w;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] w);
        @(negedge clk); wr_en = 1; wr_data = w;
        @(negedge clk); wr_en = 0; wr_data = '0;
    endtask

    task automatic wait_flag(string req, int lo, int hi);
        int n = lo;
        repeat (lo) @(negedge clk);
        chk({req, " flag early"}, rd_data[3], 0);
        while (n < hi && !rd_data[3]) begin @(negedge clk); n++; end
        chk({req, " flag due"}, rd_data[3], 1);
    endtask

    task automatic measure(string req, realtime per, realtime hi_t);
        realtime t0, t1, t2;
        repeat (3) @(posedge clk_out);
        @(posedge clk_out); t0 = $realtime;
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        chk({req, " period ns"}, longint'(t2 - t0), longint'(per));
        chk({req, " high ns"}, longint'(t1 - t0), longint'(hi_t));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 word", rd_data, 32'h0001_0001);
        chk("R1 irq", irq, 0);
        chk("R1 pwr", osc_pwr_en, 1);
    endtask

    task automatic t_stabilize();
        wait_flag("R2 eoc1", 738, 800);
        @(negedge clk);
        chk("R9 status", rd_data[4], 1);
        chk("R9 osc_ready", osc_ready, 1);
        chk("R4 masked irq", irq, 0);
    endtask

    task automatic t_mask();
        wr(mk(1, 0, 1, 0, 0, 1));
        chk("R3 write0 keeps flag", rd_data[3], 1);
        chk("R4 irq enabled", irq, 1);
    endtask

    task automatic t_clear();
        wr(mk(1, 0, 1, 1, 0, 1));
        chk("R3 w1c", rd_data[3], 0);
        chk("R4 irq after clear", irq, 0);
        repeat (300) @(negedge clk);
        chk("R5 no rearm", rd_data[3], 0);
        chk("R5 status kept", rd_data[4], 1);
    endtask

    task automatic t_power();
        wr(mk(0, 0, 1, 0, 0, 2));
        chk("R6 pwr off", osc_pwr_en, 0);
        repeat (20) @(negedge clk);
        chk("R6 status low", rd_data[4], 0);
        chk("R6 ready low", osc_ready, 0);
        wr(mk(1, 0, 1, 0, 0, 2));
        wait_flag("R6 recount eoc2", 1498, 1580);
        @(negedge clk);
        chk("R6 irq", irq, 1);
        wr(mk(1, 0, 1, 1, 0, 2));
    endtask

    task automatic t_bypass();
        wr(mk(1, 1, 1, 0, 0, 2));
        repeat (20) @(negedge clk);
        chk("R7 status low", rd_data[4], 0);
        repeat (1700) @(negedge clk);
        chk("R7 held status", rd_data[4], 0);
        chk("R7 held flag", rd_data[3], 0);
        measure("R7 bypass clock", 14, 7);
        wr(mk(1, 1, 1, 0, 2, 2));
        measure("R8 div3 bypass", 42, 14);
    endtask

    task automatic t_divider();
        wr(mk(1, 0, 1, 0, 3, 2));
        measure("R8 div4", 120, 60);
        wr(mk(1, 0, 1, 0, 4, 2));
        measure("R8 div5", 150, 60);
        wr(mk(1, 0, 1, 0, 31, 2));
        measure("R8 div32", 960, 480);
        wr(mk(1, 0, 1, 0, 0, 2));
        measure("R8 div1", 30, 15);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_stabilize();
        t_mask();
        t_clear();
        t_power();
        t_bypass();
        t_divider();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule